// File: doc/BRIEF.md
# Echo Canceller Channel Path Control

This block sits in one channel of an echo canceller, between the PCM decode and encode stages and the adaptive filter. Four control inputs set its working state: receive mute, send mute, bypass, and adaptation hold. From these it builds the receive reference that goes to the filter and the receive output. It also chooses the send output, which is either the filter's residual or the raw send input. When a path is muted, the block puts in the quiet code that matches the selected PCM coding.

Data moves one step per frame, on a single-cycle strobe `frame_i`. The receive path is two frames deep. The send path is three frames deep in normal operation and two frames deep in bypass. The filter's residual is taken in on the strobe that follows the frame in which the send sample was handed over. The block drives an adaptation enable and a single-cycle coefficient clear for the filter. When the canceller is the second half of a paired group, its own mute inputs are ignored.

Top module: `echo_path_ctrl`

## Requirements
- R1: The quiet code depends on `coding_i`: 0 (16-bit linear) gives 0000h, 1 (sign-magnitude) gives 0080h, 2 (µ-law) gives 00FFh, 3 (A-law) gives 00D5h.
- R2: With receive mute effective at a strobe, the quiet code replaces the captured receive sample. It appears on `ref_o` after that strobe and on `rout_o` after the next strobe.
- R3: With send mute effective at a strobe, `sout_o` shows the quiet code after that strobe, in every state.
- R4: In bypass, a send sample captured at strobe k appears unchanged on `sout_o` after strobe k+1, and the residual is not used.
- R5: A receive sample captured at strobe k is on `ref_o` after strobe k and on `rout_o` after strobe k+1.
- R6: Outside bypass, `snd_o` carries the send sample captured at strobe k. The residual presented during that frame is latched at strobe k+1 and reaches `sout_o` after strobe k+2.
- R7: `adapt_en_o` is high one clock after the inputs select neither bypass nor adaptation hold, and is low otherwise. When both are set, bypass wins.
- R8: `coef_clr_o` pulses high for exactly one clock, one clock after `bypass_i` rises. It stays low while bypass is held.
- R9: When `grouped_i` and `cancel_b_i` are both high, the mute inputs have no effect on `ref_o`, `rout_o` or `sout_o`.
- R10: After reset all outputs are zero. The data outputs change only on a clock where `frame_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame strobe, one clock per sample |
| coding_i | input | 2 | PCM coding: 0 linear, 1 sign-magnitude, 2 µ-law, 3 A-law |
| grouped_i | input | 1 | Canceller belongs to a paired group |
| cancel_b_i | input | 1 | This is the second canceller of the pair |
| mute_r_i | input | 1 | Receive mute request |
| mute_s_i | input | 1 | Send mute request |
| bypass_i | input | 1 | Bypass request |
| adapt_dis_i | input | 1 | Hold filter coefficients |
| rin_i | input | 16 | Receive input sample code |
| sin_i | input | 16 | Send input sample code |
| res_i | input | 16 | Residual code returned by the filter |
| ref_o | output | 16 | Receive reference to the filter |
| snd_o | output | 16 | Send sample to the filter |
| rout_o | output | 16 | Receive output |
| sout_o | output | 16 | Send output |
| adapt_en_o | output | 1 | Filter adaptation enable |
| coef_clr_o | output | 1 | Coefficient clear pulse |

## Verification
The bench gives each frame a distinct receive and send code, so latency errors show up as a mismatched value. The residual is generated as the send sample XOR a fixed pattern, which makes it clear whether `sout_o` came from the residual or from the raw input. Mute is tried under all four codings to separate the quiet codes from one another. Bypass, the grouped second canceller, and input changes between strobes are each checked against the value the path would otherwise show.

// File: rtl/echo_path_pkg.sv
package echo_path_pkg;
  typedef enum logic [1:0] {
    CODE_LIN  = 2'd0,
    CODE_SM   = 2'd1,
    CODE_MU   = 2'd2,
    CODE_ALAW = 2'd3
  } pcm_code_e;
endpackage

// File: rtl/quiet_code_sel.sv
module quiet_code_sel
  import echo_path_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        coding_i,
  output logic [DATA_W-1:0] quiet_o
);
  always_comb begin
    quiet_o = '0;
    unique case (pcm_code_e'(coding_i))
      CODE_LIN:  quiet_o = '0;
      CODE_SM:   quiet_o[7:0] = 8'h80;
      CODE_MU:   quiet_o[7:0] = 8'hFF;
      CODE_ALAW: quiet_o[7:0] = 8'hD5;
      default:   quiet_o = '0;
    endcase
  end
endmodule

// File: rtl/echo_state_dec.sv
module echo_state_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grouped_i,
  input  logic cancel_b_i,
  input  logic mute_r_i,
  input  logic mute_s_i,
  input  logic bypass_i,
  input  logic adapt_dis_i,
  output logic mute_r_o,
  output logic mute_s_o,
  output logic adapt_en_o,
  output logic coef_clr_o
);
  logic mute_gate;
  logic bypass_q;

  // second canceller of a pair never owns the mute bits
  assign mute_gate = ~(grouped_i & cancel_b_i);
  assign mute_r_o  = mute_r_i & mute_gate;
  assign mute_s_o  = mute_s_i & mute_gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_q   <= 1'b0;
      adapt_en_o <= 1'b0;
      coef_clr_o <= 1'b0;
    end else begin
      bypass_q   <= bypass_i;
      adapt_en_o <= ~bypass_i & ~adapt_dis_i;
      coef_clr_o <= bypass_i & ~bypass_q;
    end
  end

  // R8
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_clr_o |=> !coef_clr_o);

  // R7
  adapt_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bypass_i) |-> !adapt_en_o);
endmodule

// File: rtl/frame_delay.sv
module frame_delay #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         adv_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [DEPTH-1:0][DATA_W-1:0] taps_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [DATA_W-1:0] nxt;
    if (g == 0) begin : g_head
      assign nxt = data_i;
    end else begin : g_tail
      assign nxt = taps_o[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    taps_o[g] <= '0;
      else if (adv_i) taps_o[g] <= nxt;
    end
  end
endmodule

// File: rtl/echo_path_ctrl.sv
module echo_path_ctrl #(
  parameter int DATA_W   = 16,
  parameter int RX_DELAY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [1:0]        coding_i,
  input  logic              grouped_i,
  input  logic              cancel_b_i,
  input  logic              mute_r_i,
  input  logic              mute_s_i,
  input  logic              bypass_i,
  input  logic              adapt_dis_i,
  input  logic [DATA_W-1:0] rin_i,
  input  logic [DATA_W-1:0] sin_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [DATA_W-1:0] ref_o,
  output logic [DATA_W-1:0] snd_o,
  output logic [DATA_W-1:0] rout_o,
  output logic [DATA_W-1:0] sout_o,
  output logic              adapt_en_o,
  output logic              coef_clr_o
);
  localparam int RX_LAST = RX_DELAY - 1;

  logic [DATA_W-1:0]                 quiet_w;
  logic                              mute_r_w, mute_s_w;
  logic [DATA_W-1:0]                 rx_in_w;
  logic [RX_DELAY-1:0][DATA_W-1:0]   rx_taps;
  logic [DATA_W-1:0]                 s_cap_q, s_res_q, sout_q;

  quiet_code_sel #(.DATA_W(DATA_W)) u_quiet (
    .coding_i (coding_i),
    .quiet_o  (quiet_w)
  );

  echo_state_dec u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grouped_i   (grouped_i),
    .cancel_b_i  (cancel_b_i),
    .mute_r_i    (mute_r_i),
    .mute_s_i    (mute_s_i),
    .bypass_i    (bypass_i),
    .adapt_dis_i (adapt_dis_i),
    .mute_r_o    (mute_r_w),
    .mute_s_o    (mute_s_w),
    .adapt_en_o  (adapt_en_o),
    .coef_clr_o  (coef_clr_o)
  );

  // receive mute acts at capture so reference and output agree
  assign rx_in_w = mute_r_w ? quiet_w : rin_i;

  frame_delay #(.DATA_W(DATA_W), .DEPTH(RX_DELAY)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (frame_i),
    .data_i (rx_in_w),
    .taps_o (rx_taps)
  );

  assign ref_o  = rx_taps[0];
  assign rout_o = rx_taps[RX_LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_cap_q <= '0;
      s_res_q <= '0;
      sout_q  <= '0;
    end else if (frame_i) begin
      s_cap_q <= sin_i;
      s_res_q <= res_i;
      if (mute_s_w)      sout_q <= quiet_w;
      else if (bypass_i) sout_q <= s_cap_q;
      else               sout_q <= s_res_q;
    end
  end

  assign snd_o  = s_cap_q;
  assign sout_o = sout_q;

  // R10
  rout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_i) |-> $stable(rout_o) && $stable(sout_o));

  // R2
  ref_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_i && mute_r_w) |-> ref_o == $past(quiet_w));

  // R3
  sout_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_i && mute_s_w) |-> sout_o == $past(quiet_w));
endmodule

// File: tb/echo_path_ctrl_tb.sv
module echo_path_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b0;
  logic [1:0]  coding_i = 2'd0;
  logic        grouped_i = 1'b0, cancel_b_i = 1'b0;
  logic        mute_r_i = 1'b0, mute_s_i = 1'b0;
  logic        bypass_i = 1'b0, adapt_dis_i = 1'b0;
  logic [15:0] rin_i = '0, sin_i = '0, res_i;
  logic [15:0] ref_o, snd_o, rout_o, sout_o;
  logic        adapt_en_o, coef_clr_o;

  int total = 0;
  int bad   = 0;
  localparam logic [15:0] XPAT = 16'h5A5A;

  always #5 clk_i = ~clk_i;

  // stand-in filter: residual is the handed-over send sample XOR a pattern
  assign res_i = snd_o ^ XPAT;

  echo_path_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .coding_i(coding_i),
    .grouped_i(grouped_i), .cancel_b_i(cancel_b_i), .mute_r_i(mute_r_i),
    .mute_s_i(mute_s_i), .bypass_i(bypass_i), .adapt_dis_i(adapt_dis_i),
    .rin_i(rin_i), .sin_i(sin_i), .res_i(res_i), .ref_o(ref_o), .snd_o(snd_o),
    .rout_o(rout_o), .sout_o(sout_o), .adapt_en_o(adapt_en_o),
    .coef_clr_o(coef_clr_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] r, input logic [15:0] s);
    @(negedge clk_i);
    rin_i = r; sin_i = s; frame_i = 1'b1;
    @(negedge clk_i);
    frame_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 ref", ref_o, 16'h0);
    chk("R10 rout", rout_o, 16'h0);
    chk("R10 sout", sout_o, 16'h0);
    chk("R10 flags", {14'h0, adapt_en_o, coef_clr_o}, 16'h0);
  endtask

  task automatic t_normal;
    frame(16'hA001, 16'h1111);
    frame(16'hA002, 16'h2222);
    frame(16'hA003, 16'h3333);
    chk("R5 ref", ref_o, 16'hA003);
    chk("R5 rout", rout_o, 16'hA002);
    chk("R6 snd", snd_o, 16'h3333);
    chk("R6 sout", sout_o, 16'h1111 ^ XPAT);
    // inputs move without a strobe
    @(negedge clk_i); rin_i = 16'hBEEF; sin_i = 16'hCAFE;
    repeat (3) @(negedge clk_i);
    chk("R10 rout hold", rout_o, 16'hA002);
    chk("R10 sout hold", sout_o, 16'h1111 ^ XPAT);
  endtask

  task automatic t_adapt;
    @(negedge clk_i); bypass_i = 0; adapt_dis_i = 0;
    @(negedge clk_i); chk("R7 enable", {15'h0, adapt_en_o}, 16'h1);
    adapt_dis_i = 1;
    @(negedge clk_i); chk("R7 hold", {15'h0, adapt_en_o}, 16'h0);
    bypass_i = 1;
    @(negedge clk_i); chk("R7 both", {15'h0, adapt_en_o}, 16'h0);
    bypass_i = 0; adapt_dis_i = 0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_clr;
    chk("R8 idle", {15'h0, coef_clr_o}, 16'h0);
    bypass_i = 1;
    @(negedge clk_i); chk("R8 pulse", {15'h0, coef_clr_o}, 16'h1);
    @(negedge clk_i); chk("R8 single", {15'h0, coef_clr_o}, 16'h0);
    repeat (4) @(negedge clk_i);
    chk("R8 held", {15'h0, coef_clr_o}, 16'h0);
  endtask

  task automatic t_bypass;
    frame(16'hB001, 16'h4444);
    frame(16'hB002, 16'h5555);
    chk("R4 sout", sout_o, 16'h4444);
    frame(16'hB003, 16'h6666);
    chk("R4 sout next", sout_o, 16'h5555);
    chk("R5 rout byp", rout_o, 16'hB002);
    bypass_i = 0;
  endtask

  task automatic t_quiet;
    logic [15:0] q [4];
    q[0] = 16'h0000; q[1] = 16'h0080; q[2] = 16'h00FF; q[3] = 16'h00D5;
    for (int c = 0; c < 4; c++) begin
      coding_i = c[1:0];
      mute_r_i = 1; mute_s_i = 1;
      frame(16'h7E7E, 16'h1357);
      chk("R1 R2 ref quiet", ref_o, q[c]);
      chk("R1 R3 sout quiet", sout_o, q[c]);
      mute_r_i = 0; mute_s_i = 0;
      frame(16'h2468, 16'h1357);
      chk("R2 rout quiet", rout_o, q[c]);
      chk("R2 ref released", ref_o, 16'h2468);
    end
    coding_i = 2'd0;
  endtask

  task automatic t_group;
    grouped_i = 1; cancel_b_i = 1; bypass_i = 1;
    mute_r_i = 1; mute_s_i = 1; coding_i = 2'd2;
    frame(16'hC001, 16'h8888);
    frame(16'hC002, 16'h9999);
    chk("R9 ref", ref_o, 16'hC002);
    chk("R9 rout", rout_o, 16'hC001);
    chk("R9 sout", sout_o, 16'h8888);
    cancel_b_i = 0;
    frame(16'hC003, 16'hAAAA);
    chk("R9 A owns mute", ref_o, 16'h00FF);
    mute_r_i = 0; mute_s_i = 0; grouped_i = 0; bypass_i = 0; coding_i = 2'd0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_normal();
        t_adapt();
        t_clr();
        t_bypass();
        t_quiet();
        t_group();
      end
      begin
        repeat (5000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule